// File: doc/BRIEF.md
# Windowed Transmit/Receive Message Queue

This block gives a processor access to two four-deep message queues, one feeding a bus bit engine for transmission and one collecting frames the bit engine has received. The processor never names a queue slot. Each queue is reached through one fixed mailbox window of four 32-bit words: an identifier word, a length word, and two data words. For transmit, the processor fills a staging window and then writes any value to the transmit advance register. That write appends a copy of the staged message to the queue. For receive, the window always shows the oldest unread frame, and any write to the receive advance register discards that frame and moves to the next.

Each queue's fill level is held by a small state machine with three states. `FS_EMPTY` moves to `FS_PARTIAL` on an accepted append (transition *first-in*). `FS_PARTIAL` moves to `FS_FULL` when the count reaches the depth (*fill-up*) and back to `FS_EMPTY` when it reaches zero (*drain-out*). `FS_FULL` moves to `FS_PARTIAL` on an accepted removal (*make-room*). Any state moves to `FS_EMPTY` while the queue is disabled (*flush*). The bit engine side uses a valid/pop pair for transmit and a push strobe for receive. The transmit advance raises the transmit interrupt flag when the engine takes a message, and the receive side raises its flag when a frame is stored.

Address map (word addresses): mailbox *m* occupies words 4*m to 4*m+3. Transmit window = mailbox 56 (words 224..227), receive window = mailbox 60 (words 240..243). Within a window: +0 identifier, +1 length code, +2 data bytes 0..3 (byte 0 in bits 7:0), +3 data bytes 4..7. Control: 256 transmit control, 257 receive control, 258 transmit advance, 259 receive advance, 260 interrupt flags.

Top module: `mfw_window`

## Requirements
- R1: After reset, transmit control reads 0x00, receive control reads 0x80, interrupt flags read 0, `tx_valid`, `irq_tx`, `irq_rx` and `rx_overrun` are 0.
- R2: Writes to transmit window words 224..227 are held and read back; the identifier word is kept whole (bit 31 extended, bit 30 remote, standard identifier in bits 28:18), and only bits 3:0 of the length word are kept, the rest reading 0.
- R3: A write of any value to word 258 while transmit is enabled and fewer than 4 messages wait appends the staged message; transmit control bits 3:1 give the unsent count and bit 0 the enable.
- R4: `tx_valid` is high while any message waits, `tx_id`/`tx_dlc`/`tx_data` show the oldest one, and a `tx_pop` removes it so the next one appears in order the following cycle.
- R5: An advance write while 4 messages wait is ignored and sets sticky bit 4 of transmit control; a write to transmit control with bit 4 = 0 clears it, with bit 4 = 1 keeps it.
- R6: A `rx_push` while receive is enabled and not full stores the frame; receive window words 240..243 show the oldest stored frame (all zero when none), and receive control bit 7 is 1 exactly when the queue is empty.
- R7: A write of any value to word 259 discards the oldest received frame; when the queue is empty the write is ignored.
- R8: A `rx_push` while 4 frames are stored drops the new frame, keeps the stored ones, and drives `rx_overrun` high for exactly the cycle after the push.
- R9: Interrupt flag bit 0 (`irq_tx`) is set when the engine pops a message, bit 1 (`irq_rx`) when a frame is stored; writing 0 to a bit of word 260 clears it, writing 1 leaves it.
- R10: Clearing the enable bit (bit 0) of a queue's control word empties that queue; advance writes and pushes made while disabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_addr | input | ADDR_W (9) | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data for `cpu_addr` (no side effects) |
| tx_valid | output | 1 | A transmit message waits |
| tx_id | output | 32 | Oldest transmit identifier word |
| tx_dlc | output | 4 | Oldest transmit length code |
| tx_data | output | 64 | Oldest transmit data, byte 0 in bits 7:0 |
| tx_pop | input | 1 | Engine takes the oldest transmit message |
| rx_push | input | 1 | Engine delivers a received frame |
| rx_id | input | 32 | Received identifier word |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received data, byte 0 in bits 7:0 |
| rx_overrun | output | 1 | One-cycle pulse: received frame dropped |
| irq_tx | output | 1 | Transmit interrupt flag |
| irq_rx | output | 1 | Receive interrupt flag |

## Verification
A corrupted read or write pointer shows up as a message leaving or appearing out of order on the next pop or window read, so every queue test compares identifiers one by one in sequence. A fill-state machine that drifts from the real count shows the same cycle at the unsent-count field, the empty flag or `tx_valid`. A missed full state shows one cycle later as a fifth entry accepted, a missing overflow bit or a missing overrun pulse. A wrapped pointer is exposed by running each queue past its depth and then reading it back.

// File: rtl/mfw_pkg.sv
package mfw_pkg;

    typedef struct packed {
        logic [31:0] id;
        logic [3:0]  dlc;
        logic [63:0] data;
    } mfw_entry_t;

    typedef enum logic [1:0] {
        FS_EMPTY   = 2'd0,
        FS_PARTIAL = 2'd1,
        FS_FULL    = 2'd2
    } mfw_fill_e;

endpackage

// File: rtl/mfw_fifo.sv
module mfw_fifo
    import mfw_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  mfw_entry_t    push_entry,
    input  logic          pop,
    output mfw_entry_t    head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          push_acc,
    output logic          pop_acc,
    output logic          push_drop
);
    localparam int PW = $clog2(DEPTH);

    mfw_fill_e     state, state_nx;
    logic [CW-1:0] count_nx;
    logic [PW-1:0] wr_ptr, rd_ptr;
    mfw_entry_t    mem [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // outputs decoded from the fill state
    always_comb begin
        empty     = (state == FS_EMPTY);
        full      = (state == FS_FULL);
        push_acc  = push && !full && !flush;
        pop_acc   = pop && !empty && !flush;
        push_drop = push && full && !flush;
        head      = empty ? '0 : mem[rd_ptr];
        count_nx  = count + CW'(push_acc) - CW'(pop_acc);
    end

    // fill-state transitions
    always_comb begin
        state_nx = state;
        if (flush) begin
            state_nx = FS_EMPTY;
        end else begin
            unique case (state)
                FS_EMPTY:   if (push_acc) state_nx = FS_PARTIAL;
                FS_PARTIAL: begin
                    if (count_nx == CW'(DEPTH)) state_nx = FS_FULL;
                    else if (count_nx == '0)    state_nx = FS_EMPTY;
                end
                FS_FULL:    if (pop_acc) state_nx = FS_PARTIAL;
                default:    state_nx = FS_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= FS_EMPTY;
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            state  <= FS_EMPTY;
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            state <= state_nx;
            count <= count_nx;
            if (push_acc) wr_ptr <= bump(wr_ptr);
            if (pop_acc)  rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (push_acc) mem[wr_ptr] <= push_entry;
    end

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (full && count == $past(count))); // R5

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> empty); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (count == $past(count) || count == $past(count) + 1'b1
                    || count + 1'b1 == $past(count))); // R4

    AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R3

endmodule

// File: rtl/mfw_stage.sv
module mfw_stage
    import mfw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [1:0]  sel,
    input  logic [31:0] wdata,
    output mfw_entry_t  entry
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry <= '0;
        end else if (wr) begin
            unique case (sel)
                2'd0: entry.id           <= wdata;
                2'd1: entry.dlc          <= wdata[3:0];
                2'd2: entry.data[31:0]   <= wdata;
                2'd3: entry.data[63:32]  <= wdata;
                default: ;
            endcase
        end
    end

    AST_DLC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 2'd1) |=> entry.dlc == $past(wdata[3:0])); // R2
endmodule

// File: rtl/mfw_irq.sv
module mfw_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_tx,
    input  logic       set_rx,
    input  logic       wr,
    input  logic [1:0] wdata,
    output logic       irq_tx,
    output logic       irq_rx
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_tx <= 1'b0;
            irq_rx <= 1'b0;
        end else begin
            if (set_tx)                irq_tx <= 1'b1;
            else if (wr && !wdata[0])  irq_tx <= 1'b0;
            if (set_rx)                irq_rx <= 1'b1;
            else if (wr && !wdata[1])  irq_rx <= 1'b0;
        end
    end

    AST_IRQ_TX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_tx |=> irq_tx); // R9
    AST_IRQ_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_rx |=> irq_rx); // R9
endmodule

// File: rtl/mfw_window.sv
module mfw_window
    import mfw_pkg::*;
#(
    parameter int DEPTH    = 4,   // at most 7: count field is 3 bits
    parameter int ADDR_W   = 9,
    parameter int TX_MBX   = 56,
    parameter int RX_MBX   = 60,
    parameter int CTL_BASE = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              tx_valid,
    output logic [31:0]       tx_id,
    output logic [3:0]        tx_dlc,
    output logic [63:0]       tx_data,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [31:0]       rx_id,
    input  logic [3:0]        rx_dlc,
    input  logic [63:0]       rx_data,
    output logic              rx_overrun,
    output logic              irq_tx,
    output logic              irq_rx
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [ADDR_W-3:0] TX_IDX  = (ADDR_W-2)'(TX_MBX);
    localparam logic [ADDR_W-3:0] RX_IDX  = (ADDR_W-2)'(RX_MBX);
    localparam logic [ADDR_W-1:0] A_TXCTL = ADDR_W'(CTL_BASE);
    localparam logic [ADDR_W-1:0] A_RXCTL = ADDR_W'(CTL_BASE + 1);
    localparam logic [ADDR_W-1:0] A_TXADV = ADDR_W'(CTL_BASE + 2);
    localparam logic [ADDR_W-1:0] A_RXADV = ADDR_W'(CTL_BASE + 3);
    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(CTL_BASE + 4);

    logic          tx_en, rx_en, tx_ovf;
    logic          tx_win_hit, rx_win_hit;
    logic          wr_txctl, wr_rxctl, wr_txadv, wr_rxadv, wr_flags;
    mfw_entry_t    staged, tx_head, rx_head, rx_in;
    logic [CW-1:0] tx_count, rx_count;
    logic          tx_empty, tx_full, rx_empty, rx_full;
    logic          tx_push_acc, tx_pop_acc, tx_drop;
    logic          rx_push_acc, rx_pop_acc, rx_drop;

    always_comb begin
        tx_win_hit = (cpu_addr[ADDR_W-1:2] == TX_IDX);
        rx_win_hit = (cpu_addr[ADDR_W-1:2] == RX_IDX);
        wr_txctl   = cpu_wr && (cpu_addr == A_TXCTL);
        wr_rxctl   = cpu_wr && (cpu_addr == A_RXCTL);
        wr_txadv   = cpu_wr && (cpu_addr == A_TXADV);
        wr_rxadv   = cpu_wr && (cpu_addr == A_RXADV);
        wr_flags   = cpu_wr && (cpu_addr == A_FLAGS);
        rx_in      = '{id: rx_id, dlc: rx_dlc, data: rx_data};
    end

    mfw_stage u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cpu_wr && tx_win_hit),
        .sel   (cpu_addr[1:0]),
        .wdata (cpu_wdata),
        .entry (staged)
    );

    mfw_fifo #(.DEPTH(DEPTH), .CW(CW)) u_txq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (!tx_en),
        .push       (wr_txadv),
        .push_entry (staged),
        .pop        (tx_pop),
        .head       (tx_head),
        .count      (tx_count),
        .empty      (tx_empty),
        .full       (tx_full),
        .push_acc   (tx_push_acc),
        .pop_acc    (tx_pop_acc),
        .push_drop  (tx_drop)
    );

    mfw_fifo #(.DEPTH(DEPTH), .CW(CW)) u_rxq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (!rx_en),
        .push       (rx_push),
        .push_entry (rx_in),
        .pop        (wr_rxadv),
        .head       (rx_head),
        .count      (rx_count),
        .empty      (rx_empty),
        .full       (rx_full),
        .push_acc   (rx_push_acc),
        .pop_acc    (rx_pop_acc),
        .push_drop  (rx_drop)
    );

    mfw_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_tx (tx_pop_acc),
        .set_rx (rx_push_acc),
        .wr     (wr_flags),
        .wdata  (cpu_wdata[1:0]),
        .irq_tx (irq_tx),
        .irq_rx (irq_rx)
    );

    // control state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en      <= 1'b0;
            rx_en      <= 1'b0;
            tx_ovf     <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            if (wr_txctl) tx_en <= cpu_wdata[0];
            if (wr_rxctl) rx_en <= cpu_wdata[0];
            if (tx_drop)       tx_ovf <= 1'b1;
            else if (wr_txctl) tx_ovf <= tx_ovf & cpu_wdata[4];
            rx_overrun <= rx_drop;
        end
    end

    // outputs
    always_comb begin
        tx_valid = !tx_empty;
        tx_id    = tx_head.id;
        tx_dlc   = tx_head.dlc;
        tx_data  = tx_head.data;
        cpu_rdata = '0;
        if (tx_win_hit || rx_win_hit) begin
            unique case (cpu_addr[1:0])
                2'd0: cpu_rdata = tx_win_hit ? staged.id : rx_head.id;
                2'd1: cpu_rdata = {28'd0, tx_win_hit ? staged.dlc : rx_head.dlc};
                2'd2: cpu_rdata = tx_win_hit ? staged.data[31:0] : rx_head.data[31:0];
                2'd3: cpu_rdata = tx_win_hit ? staged.data[63:32] : rx_head.data[63:32];
                default: cpu_rdata = '0;
            endcase
        end else if (cpu_addr == A_TXCTL) begin
            cpu_rdata = {27'd0, tx_ovf, 3'(tx_count), tx_en};
        end else if (cpu_addr == A_RXCTL) begin
            cpu_rdata = {24'd0, rx_empty, 6'd0, rx_en};
        end else if (cpu_addr == A_FLAGS) begin
            cpu_rdata = {30'd0, irq_rx, irq_tx};
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ovf) |-> $past(wr_txadv)); // R5

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> $past(rx_push)); // R8

    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !tx_valid); // R10

    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (rx_count == '0)); // R10

    AST_RX_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_en && !rx_full) |=> !rx_empty); // R6

    AST_TX_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push_acc |=> tx_valid); // R3

    AST_RX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop_acc && !rx_push) |=> (rx_count + 1'b1 == $past(rx_count))); // R7

endmodule

// File: tb/mfw_window_test.sv
module mfw_window_test;
    localparam int A_TXCTL = 256, A_RXCTL = 257, A_TXADV = 258, A_RXADV = 259, A_FLAGS = 260;
    localparam int TXW = 224, RXW = 240;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [8:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        tx_valid;
    logic [31:0] tx_id;
    logic [3:0]  tx_dlc;
    logic [63:0] tx_data;
    logic        tx_pop = 1'b0;
    logic        rx_push = 1'b0;
    logic [31:0] rx_id = '0;
    logic [3:0]  rx_dlc = '0;
    logic [63:0] rx_data = '0;
    logic        rx_overrun, irq_tx, irq_rx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    mfw_window uut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tx_valid(tx_valid),
        .tx_id(tx_id), .tx_dlc(tx_dlc), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_id(rx_id), .rx_dlc(rx_dlc), .rx_data(rx_data),
        .rx_overrun(rx_overrun), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 9'(addr); cpu_wdata = data;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        cpu_addr = 9'(addr);
        #1;
        data = cpu_rdata;
    endtask

    task automatic pop_tx();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic push_rx(input logic [31:0] id, input logic [3:0] dlc, input logic [63:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_id = id; rx_dlc = dlc; rx_data = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic stage(input logic [31:0] id, input logic [31:0] dlc, input logic [63:0] d);
        wr(TXW + 0, id);
        wr(TXW + 1, dlc);
        wr(TXW + 2, d[31:0]);
        wr(TXW + 3, d[63:32]);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_TXCTL, v); check("R1 txctl", v, 32'h0);
        rd(A_RXCTL, v); check("R1 rxctl", v, 32'h80);
        rd(A_FLAGS, v); check("R1 flags", v, 32'h0);
        check("R1 outputs", {tx_valid, irq_tx, irq_rx, rx_overrun}, 4'b0);
    endtask

    task automatic t_stage();
        logic [31:0] v;
        stage(32'h8000_1234, 32'hFFFF_FFFF, 64'h8877_6655_4433_2211);
        rd(TXW + 0, v); check("R2 id", v, 32'h8000_1234);
        rd(TXW + 1, v); check("R2 dlc low bits only", v, 32'h0000_000F);
        rd(TXW + 2, v); check("R2 data lo", v, 32'h4433_2211);
        rd(TXW + 3, v); check("R2 data hi", v, 32'h8877_6655);
    endtask

    task automatic t_commit_order();
        logic [31:0] v;
        wr(A_TXCTL, 32'h1);
        stage(32'h123 << 18, 32'h2, 64'h0000_0000_0000_BEEF);
        wr(A_TXADV, 32'hFF);
        stage(32'hC000_0005, 32'h0, 64'h0);
        wr(A_TXADV, 32'hFF);
        rd(A_TXCTL, v); check("R3 count 2", v, 32'h5);
        check("R4 valid", tx_valid, 1'b1);
        check("R4 first id", tx_id, 32'h048C_0000);
        check("R4 first dlc", tx_dlc, 4'h2);
        check("R4 first data", tx_data, 64'hBEEF);
        pop_tx();
        check("R4 second id", tx_id, 32'hC000_0005);
        rd(A_TXCTL, v); check("R4 count 1", v, 32'h3);
        check("R9 irq_tx set on pop", irq_tx, 1'b1);
        pop_tx();
        check("R4 drained", tx_valid, 1'b0);
        pop_tx();
        rd(A_TXCTL, v); check("R4 pop on empty ignored", v, 32'h1);
        wr(A_FLAGS, 32'h2);
        check("R9 irq_tx cleared by 0", irq_tx, 1'b0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            stage(32'(i + 10), 32'h1, 64'(i));
            wr(A_TXADV, 32'hFF);
        end
        rd(A_TXCTL, v); check("R3 count 4", v, 32'h9);
        stage(32'd99, 32'h1, 64'h0);
        wr(A_TXADV, 32'hFF);
        rd(A_TXCTL, v); check("R5 overflow sticky, count kept", v, 32'h19);
        check("R5 head unchanged", tx_id, 32'd10);
        pop_tx();
        rd(A_TXCTL, v); check("R5 ovf survives pop", v, 32'h17);
        wr(A_TXCTL, 32'h11);
        rd(A_TXCTL, v); check("R5 write 1 keeps ovf", v, 32'h17);
        wr(A_TXCTL, 32'h01);
        rd(A_TXCTL, v); check("R5 write 0 clears ovf", v, 32'h07);
        for (int i = 1; i < 4; i++) begin
            check("R4 wrap order", tx_id, 32'(i + 10));
            pop_tx();
        end
        check("R4 empty after wrap", tx_valid, 1'b0);
        wr(A_FLAGS, 32'h0);
    endtask

    task automatic t_tx_disable();
        logic [31:0] v;
        wr(A_TXADV, 32'hFF);
        wr(A_TXADV, 32'hFF);
        wr(A_TXCTL, 32'h0);
        @(negedge clk);
        check("R10 tx flushed", tx_valid, 1'b0);
        wr(A_TXADV, 32'hFF);
        @(negedge clk);
        rd(A_TXCTL, v); check("R10 commit while disabled ignored", v, 32'h0);
        check("R10 no tx while disabled", tx_valid, 1'b0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        push_rx(32'hDEAD, 4'h3, 64'h1);
        wr(A_RXCTL, 32'h1);
        rd(A_RXCTL, v); check("R10 push while disabled ignored", v, 32'h81);
        check("R10 irq_rx untouched", irq_rx, 1'b0);
        push_rx(32'h8001_0001, 4'h8, 64'h0807_0605_0403_0201);
        push_rx(32'h0040_0000, 4'h1, 64'h00AA);
        rd(A_RXCTL, v); check("R6 not empty", v, 32'h01);
        rd(RXW + 0, v); check("R6 head id", v, 32'h8001_0001);
        rd(RXW + 1, v); check("R6 head dlc", v, 32'h8);
        rd(RXW + 2, v); check("R6 head data lo", v, 32'h0403_0201);
        rd(RXW + 3, v); check("R6 head data hi", v, 32'h0807_0605);
        check("R9 irq_rx set on store", irq_rx, 1'b1);
        wr(A_FLAGS, 32'h3);
        check("R9 write 1 keeps irq_rx", irq_rx, 1'b1);
        wr(A_FLAGS, 32'h1);
        check("R9 write 0 clears irq_rx", irq_rx, 1'b0);
        wr(A_RXADV, 32'hFF);
        rd(RXW + 0, v); check("R7 next frame", v, 32'h0040_0000);
        wr(A_RXADV, 32'h0);
        rd(A_RXCTL, v); check("R7 empty after releases", v, 32'h81);
        rd(RXW + 0, v); check("R6 window zero when empty", v, 32'h0);
        wr(A_RXADV, 32'hFF);
        rd(A_RXCTL, v); check("R7 release on empty ignored", v, 32'h81);
        push_rx(32'h0000_0777, 4'h2, 64'h0);
        rd(RXW + 0, v); check("R7 pointers intact", v, 32'h0000_0777);
        wr(A_RXADV, 32'hFF);
        wr(A_FLAGS, 32'h0);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        for (int i = 1; i <= 4; i++) begin
            push_rx(32'(i), 4'h1, 64'(i));
            check("R8 no overrun while room", rx_overrun, 1'b0);
        end
        push_rx(32'd5, 4'h1, 64'd5);
        check("R8 overrun pulse", rx_overrun, 1'b1);
        @(negedge clk);
        check("R8 overrun one cycle", rx_overrun, 1'b0);
        for (int i = 1; i <= 4; i++) begin
            rd(RXW + 0, v); check("R8 stored frames kept in order", v, 32'(i));
            wr(A_RXADV, 32'hFF);
        end
        rd(A_RXCTL, v); check("R8 dropped frame absent", v, 32'h81);
        push_rx(32'd6, 4'h0, 64'd0);
        wr(A_RXCTL, 32'h0);
        @(negedge clk);
        wr(A_RXCTL, 32'h1);
        rd(A_RXCTL, v); check("R10 rx flushed by disable", v, 32'h81);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stage();
        t_commit_order();
        t_overflow();
        t_tx_disable();
        t_rx();
        t_overrun();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule